// File: doc/BRIEF.md
# Dual Fan Tachometer Period Counter

This block measures the speed of two fans. For each fan it counts reference ticks between one rising edge of the tachometer signal and the next. A slow fan gives a long period and a large count. A fast fan gives a short period and a small count. Each channel selects its own tick rate from four binary-divided rates, derived from one shared prescaler that runs off the system clock. The fastest rate is nominally 25 kHz, and the others are one half, one quarter and one eighth of it.

Each channel keeps only the count of its most recent complete period. The running count stops at its ceiling instead of wrapping around. A period that holds more ticks than the ceiling can raise a sticky fault. Software clears that fault by writing a one to the fault's bit. Configuration is written through a per-channel strobe that carries a rate code and a fault-enable bit. The tachometer inputs are asynchronous and are synchronized inside the block.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, every count output and fault output is 0. Every channel's rate code is 3 (slowest rate), and its fault enable is off.
- R2: The rate code selects the tick spacing in clock cycles: code 0 gives TICK_DIV, code 1 gives 2*TICK_DIV, code 2 gives 4*TICK_DIV, and code 3 gives 8*TICK_DIV. Ticks of each rate are strictly periodic.
- R3: When consecutive tach rising edges are P clock cycles apart, and P is a multiple of the tick spacing T, the stored count is exactly P/T (below saturation).
- R4: A channel's count output changes only when a completed period is stored. A new store replaces the earlier value.
- R5: The first rising edge after reset, or after a configuration write that changes the channel's rate code, starts a measurement and stores nothing.
- R6: The count saturates at 255. A period of 255 or more ticks stores 255.
- R7: A channel's fault sets when a period of more than 255 ticks is stored while that channel's fault enable is on. A period of exactly 255 ticks, or any period while the enable is off, sets no fault.
- R8: A fault is sticky. It is cleared only by a cycle with clr_we high and the channel's bit set in clr_mask (bit 0 is channel A, bit 1 is channel B). Clearing one channel leaves the other channel's fault unchanged.
- R9: The channels are independent. Activity or configuration on one channel leaves the other channel's count and fault unchanged.
- R10: The tach input passes through a two-flop synchronizer. A rising edge of the raw input updates the count output at the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | NCH | Raw asynchronous tachometer signals, bit i is channel i |
| cfg_we | input | NCH | Per-channel configuration write strobe |
| cfg_rate | input | 2 | Rate code written by cfg_we (0 fastest, 3 slowest) |
| cfg_fault_en | input | 1 | Fault enable written by cfg_we |
| clr_we | input | 1 | Fault clear strobe |
| clr_mask | input | NCH | Write-1-to-clear mask for the fault bits |
| count_out | output | NCH*8 | Latest completed counts, channel i in bits [8i+7:8i] |
| fault_out | output | NCH | Sticky overflow fault per channel |

## Verification
The assertions check on every cycle that the slower tick enables occur only together with the faster ones, and that the fastest tick is never repeated on adjacent cycles. They also check that a count holds in any cycle without a synchronized edge, that a fault rises only on an edge cycle with its enable on, that it falls only on a matching clear, and that reset leaves everything at zero. Only the bench scenarios can show exact tick counts for given periods, the 255/256 boundary between plain saturation and a fault, the suppressed store after a rate change, the three-cycle edge latency, and channel independence under concurrent traffic.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W     = 8;
    localparam int RATE_W    = 2;
    localparam int NUM_RATES = 1 << RATE_W;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Rate code: tick spacing is TICK_DIV shifted left by the code
    typedef enum logic [RATE_W-1:0] {
        RATE_DIV1 = 2'd0,
        RATE_DIV2 = 2'd1,
        RATE_DIV4 = 2'd2,
        RATE_DIV8 = 2'd3
    } tach_rate_e;

    localparam tach_rate_e RATE_RESET = RATE_DIV8;

    typedef struct packed {
        tach_rate_e rate;
        logic       fault_en;
    } chan_cfg_t;

    typedef struct packed {
        logic             armed;
        logic             ovf;
        logic [CNT_W-1:0] run;
    } chan_run_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    function automatic logic would_overflow(input logic [CNT_W-1:0] v, input logic tick);
        return tick && (v == CNT_MAX);
    endfunction

endpackage

// File: rtl/tach_prescaler.sv
module tach_prescaler
    import fan_tach_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int NUM_OUT  = NUM_RATES
) (
    input  logic               clk,
    input  logic               rst,
    output logic [NUM_OUT-1:0] tick
);

    localparam int BW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int DW = (NUM_OUT > 1) ? NUM_OUT - 1 : 1;

    logic [BW-1:0] base_cnt;
    logic          base_tick;
    logic [DW-1:0] oct_cnt;

    assign base_tick = (base_cnt == BW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_cnt <= '0;
        end else if (base_tick) begin
            base_cnt <= '0;
        end else begin
            base_cnt <= base_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oct_cnt <= '0;
        end else if (base_tick) begin
            oct_cnt <= oct_cnt + 1'b1;
        end
    end

    assign tick[0] = base_tick;

    generate
        for (genvar j = 1; j < NUM_OUT; j++) begin : g_div
            assign tick[j] = base_tick & (&oct_cnt[j-1:0]);
        end
    endgenerate

endmodule

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic rise
);

    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], raw};
        end
    end

    // shreg[SYNC_STAGES-1] is the synchronized level, the top bit its delayed copy
    assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

endmodule

// File: rtl/tach_channel.sv
module tach_channel
    import fan_tach_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RATES-1:0] ticks,
    input  logic                 rise,
    input  logic                 cfg_we,
    input  tach_rate_e           cfg_rate,
    input  logic                 cfg_fen,
    input  logic                 clr,
    output logic [CNT_W-1:0]     count,
    output logic                 fault,
    output logic                 fen
);

    chan_cfg_t cfg_q;
    chan_run_t run_q, run_n;
    logic      tick_sel;
    logic      rate_chg;
    logic      store;
    logic      set_fault;

    assign tick_sel = ticks[cfg_q.rate];
    assign rate_chg = cfg_we && (cfg_rate != cfg_q.rate);
    assign fen      = cfg_q.fault_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{rate: RATE_RESET, fault_en: 1'b0};
        end else if (cfg_we) begin
            cfg_q <= '{rate: cfg_rate, fault_en: cfg_fen};
        end
    end

    always_comb begin
        run_n     = run_q;
        store     = 1'b0;
        set_fault = 1'b0;
        if (rate_chg) begin
            // restart: next edge only arms
            run_n = '{armed: 1'b0, ovf: 1'b0, run: '0};
        end else if (rise) begin
            store       = run_q.armed;
            set_fault   = run_q.armed & run_q.ovf & cfg_q.fault_en;
            run_n.armed = 1'b1;
            run_n.ovf   = 1'b0;
            run_n.run   = tick_sel ? CNT_W'(1) : '0;
        end else begin
            if (would_overflow(run_q.run, tick_sel)) begin
                run_n.ovf = 1'b1;
            end
            if (tick_sel) begin
                run_n.run = sat_inc(run_q.run);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '{armed: 1'b0, ovf: 1'b0, run: '0};
        end else begin
            run_q <= run_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (store) begin
            count <= run_q.run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault <= 1'b0;
        end else if (set_fault) begin
            fault <= 1'b1;
        end else if (clr) begin
            fault <= 1'b0;
        end
    end

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int TICK_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       tach_in,
    input  logic [NCH-1:0]       cfg_we,
    input  logic [RATE_W-1:0]    cfg_rate,
    input  logic                 cfg_fault_en,
    input  logic                 clr_we,
    input  logic [NCH-1:0]       clr_mask,
    output logic [NCH*CNT_W-1:0] count_out,
    output logic [NCH-1:0]       fault_out
);

    logic [NUM_RATES-1:0] tick_en;
    logic [NCH-1:0]       rise_vec;
    logic [NCH-1:0]       fen_vec;
    tach_rate_e           rate_in;

    assign rate_in = tach_rate_e'(cfg_rate);

    tach_prescaler #(
        .TICK_DIV (TICK_DIV),
        .NUM_OUT  (NUM_RATES)
    ) presc_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_en)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            tach_edge_sync #(
                .SYNC_STAGES (2)
            ) sync_i (
                .clk  (clk),
                .rst  (rst),
                .raw  (tach_in[i]),
                .rise (rise_vec[i])
            );

            tach_channel chan_i (
                .clk      (clk),
                .rst      (rst),
                .ticks    (tick_en),
                .rise     (rise_vec[i]),
                .cfg_we   (cfg_we[i]),
                .cfg_rate (rate_in),
                .cfg_fen  (cfg_fault_en),
                .clr      (clr_we & clr_mask[i]),
                .count    (count_out[i*CNT_W +: CNT_W]),
                .fault    (fault_out[i]),
                .fen      (fen_vec[i])
            );
        end
    endgenerate

endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker
    import fan_tach_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int TICK_DIV = 4,
    parameter int NUM_T    = NUM_RATES
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_T-1:0]     tick,
    input logic [NCH-1:0]       rise,
    input logic [NCH-1:0]       fen,
    input logic                 clr_we,
    input logic [NCH-1:0]       clr_mask,
    input logic [NCH*CNT_W-1:0] count_out,
    input logic [NCH-1:0]       fault_out
);

    generate
        for (genvar j = 1; j < NUM_T; j++) begin : g_nest
            assert_tick_nest_R2: assert property (@(posedge clk) disable iff (rst)
                tick[j] |-> tick[j-1]);
        end

        if (TICK_DIV > 1) begin : g_gap
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
                tick[0] |=> !tick[0]);
        end

        for (genvar i = 0; i < NCH; i++) begin : g_chk
            assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (count_out[i*CNT_W +: CNT_W] == '0) && !fault_out[i]);

            assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
                !rise[i] |=> $stable(count_out[i*CNT_W +: CNT_W]));

            assert_fault_cause_R7: assert property (@(posedge clk) disable iff (rst)
                $rose(fault_out[i]) |-> $past(rise[i] && fen[i]));

            assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
                $fell(fault_out[i]) |-> $past(clr_we && clr_mask[i]));
        end
    endgenerate

endmodule

bind fan_tach_meter fan_tach_checker #(
    .NCH      (NCH),
    .TICK_DIV (TICK_DIV),
    .NUM_T    (fan_tach_pkg::NUM_RATES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .rise      (rise_vec),
    .fen       (fen_vec),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .count_out (count_out),
    .fault_out (fault_out)
);

// File: tb/fan_tach_meter_tb_top.sv
module fan_tach_meter_tb_top;
    import fan_tach_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int TDIV       = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCH-1:0]       tach = '0;
    logic [NCH-1:0]       cfg_we = '0;
    logic [RATE_W-1:0]    cfg_rate = '0;
    logic                 cfg_fault_en = 1'b0;
    logic                 clr_we = 1'b0;
    logic [NCH-1:0]       clr_mask = '0;
    logic [NCH*CNT_W-1:0] count_out;
    logic [NCH-1:0]       fault_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cur_rate [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_tach_meter #(.NCH(NCH), .TICK_DIV(TDIV)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tach_in      (tach),
        .cfg_we       (cfg_we),
        .cfg_rate     (cfg_rate),
        .cfg_fault_en (cfg_fault_en),
        .clr_we       (clr_we),
        .clr_mask     (clr_mask),
        .count_out    (count_out),
        .fault_out    (fault_out)
    );

    function automatic int tick_cycles(input int sel);
        return TDIV << sel;
    endfunction

    function automatic int exp_count(input int ticks);
        return (ticks > 255) ? 255 : ticks;
    endfunction

    function automatic int cnt_of(input int ch);
        return int'(count_out[ch*CNT_W +: CNT_W]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input int sel, input bit fen);
        @(negedge clk);
        cfg_we[ch]   = 1'b1;
        cfg_rate     = RATE_W'(sel);
        cfg_fault_en = fen;
        @(negedge clk);
        cfg_we       = '0;
        cur_rate[ch] = sel;
    endtask

    // guarantees a rate change so the channel restarts unarmed
    task automatic set_fresh(input int ch, input int sel, input bit fen);
        if (cur_rate[ch] == sel) cfg_write(ch, (sel + 1) % 4, fen);
        cfg_write(ch, sel, fen);
    endtask

    // one rising edge, then the rest of a P-cycle period; called at a negedge
    task automatic one_edge(input int ch, input int period);
        tach[ch] = 1'b1;
        repeat (period / 2) @(negedge clk);
        tach[ch] = 1'b0;
        repeat (period - period / 2) @(negedge clk);
    endtask

    task automatic clear_fault(input logic [NCH-1:0] mask);
        @(negedge clk);
        clr_we   = 1'b1;
        clr_mask = mask;
        @(negedge clk);
        clr_we   = 1'b0;
        clr_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < NCH; c++) cur_rate[c] = 3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count A after reset", cnt_of(0), 0);
        chk("R1 count B after reset", cnt_of(1), 0);
        chk("R1 faults after reset", int'(fault_out), 0);

        // R1/R2 default slowest rate, R5 first edge arms only
        one_edge(0, 5 * tick_cycles(3));
        chk("R5 first edge after reset stores nothing", cnt_of(0), 0);
        one_edge(0, 5 * tick_cycles(3));
        chk("R3 default rate code 3 count", cnt_of(0), 5);

        // R1 fault disabled by default, R6 saturation at default rate
        one_edge(1, 256 * tick_cycles(3));
        one_edge(1, 16);
        chk("R6 default rate saturated count B", cnt_of(1), 255);
        chk("R1 fault stays off with default enable", int'(fault_out[1]), 0);

        // R9 concurrent independent channels, R2 two rates
        set_fresh(0, 1, 1'b0);
        set_fresh(1, 2, 1'b0);
        fork
            begin repeat (3) one_edge(0, 12 * tick_cycles(1)); end
            begin repeat (3) one_edge(1, 7 * tick_cycles(2)); end
        join
        chk("R9 channel A concurrent count", cnt_of(0), 12);
        chk("R9 channel B concurrent count", cnt_of(1), 7);

        // random periods and rates
        for (int it = 0; it < 12; it++) begin
            int ch, oth, sel, k, prev, oth_cnt, period;
            bit fen;
            ch      = int'($urandom % 2);
            oth     = 1 - ch;
            sel     = (cur_rate[ch] + 1 + int'($urandom % 3)) % 4;
            k       = 1 + int'($urandom % ((sel == 3) ? 25 : 60));
            fen     = bit'($urandom % 2);
            period  = k * tick_cycles(sel);
            prev    = cnt_of(ch);
            oth_cnt = cnt_of(oth);
            cfg_write(ch, sel, fen);
            one_edge(ch, period);
            chk("R5 edge after rate change keeps old count", cnt_of(ch), prev);
            one_edge(ch, period);
            chk("R3 random period count", cnt_of(ch), exp_count(k));
            one_edge(ch, period);
            chk("R2 random rate repeat count", cnt_of(ch), exp_count(k));
            chk("R9 other channel count untouched", cnt_of(oth), oth_cnt);
            chk("R7 no fault below ceiling", int'(fault_out[ch]), 0);
        end

        // R6/R7 saturation with fault disabled
        set_fresh(0, 0, 1'b0);
        one_edge(0, 300 * tick_cycles(0));
        one_edge(0, 20);
        chk("R6 saturated count A", cnt_of(0), 255);
        chk("R7 no fault while disabled", int'(fault_out[0]), 0);

        // R7 boundary 255 vs 256 with fault enabled
        set_fresh(0, 0, 1'b1);
        one_edge(0, 255 * tick_cycles(0));
        one_edge(0, 256 * tick_cycles(0));
        chk("R6 exactly 255 ticks", cnt_of(0), 255);
        chk("R7 no fault at exactly 255", int'(fault_out[0]), 0);
        one_edge(0, 10 * tick_cycles(0));
        chk("R6 256 ticks saturates", cnt_of(0), 255);
        chk("R7 fault on 256 ticks", int'(fault_out[0]), 1);
        chk("R9 fault B untouched", int'(fault_out[1]), 0);
        one_edge(0, 10 * tick_cycles(0));
        chk("R4 new period replaces saturated value", cnt_of(0), 10);
        chk("R8 fault sticky after good period", int'(fault_out[0]), 1);

        // R8 write-1-to-clear per channel
        clear_fault(2'b10);
        chk("R8 clearing B leaves A fault", int'(fault_out[0]), 1);
        clear_fault(2'b01);
        chk("R8 clearing A bit", int'(fault_out[0]), 0);

        // R10 latency through synchronizer
        set_fresh(1, 0, 1'b0);
        one_edge(1, 7 * tick_cycles(0));
        one_edge(1, 9 * tick_cycles(0));
        chk("R3 count before latency test", cnt_of(1), 7);
        tach[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 no update two clocks after edge", cnt_of(1), 7);
        @(negedge clk);
        chk("R10 update at third clock after edge", cnt_of(1), 9);
        repeat (4) @(negedge clk);
        tach[1] = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule